// File: doc/BRIEF.md
# Programmable-Polynomial CRC Shift-Register Engine

This block computes a cyclic redundancy check with a shift register whose feedback polynomial and degree are chosen at run time. The host loads a polynomial of up to 32 bits, a degree field, and a seed. It then starts a computation by clearing the register or by loading the seed. The seed can be loaded either as written or with its 32 bits mirrored end to end. Data words then arrive on a valid/ready stream. Each word carries a count of how many of its low bits are meaningful. The engine folds those bits into the register, least significant bit first, in one clock cycle per word.

The register contents are the running check value and are always visible on `state_q`. The register can also be overwritten directly, so a partial result can be parked and resumed later.

The stream interface applies back-pressure in one case only. `in_ready` drops, combinationally, in any cycle where the clear, seed-load or direct-write strobe is high. A word offered in such a cycle is not taken and must be held until `in_ready` is high again. In every other cycle `in_ready` is high, and a word is taken on each rising edge where both `in_valid` and `in_ready` are high.

Top module: `crc_lfsr_engine`

## Requirements
- R1: After reset, every register reads zero: polynomial, degree field, seed, mirror flag and check state. A `poly_wr` pulse makes `poly_q` equal to `poly_wdata` one cycle later.
- R2: The 5-bit degree field `width_q` is set/clear. Its next value is `(width_q & ~clr) | set`, where each term counts only when its strobe is high, so set wins for a bit that is named in both. The effective CRC degree N is `width_q + 1` (1 to 32), and only bits N-1..0 of the polynomial and the state take part.
- R3: `swap_q` is sticky. A `swap_set` pulse sets it and a `swap_clr` pulse resets it; if both are high, set wins. `init_wr` makes `init_q` equal to `init_wdata` one cycle later.
- R4: `clear_stb` makes `state_q` zero on the next cycle. It overrides a seed load, a direct write and data in the same cycle.
- R5: `init_stb` without `clear_stb` loads `state_q` on the next cycle. The value loaded is `init_q` when `swap_q` is 0, or `init_q` with bit i moved to bit 31-i when `swap_q` is 1, in both cases masked to the low N bits. The seed load overrides a direct write.
- R6: `state_wr` without `clear_stb` or `init_stb` makes `state_q` equal to `state_wdata` masked to the low N bits, one cycle later.
- R7: `in_ready` is 0 exactly in cycles where `clear_stb`, `init_stb` or `state_wr` is high. A word is taken when `in_valid` and `in_ready` are both high. With no strobe and no word taken, `state_q` does not change.
- R8: A taken word updates the state in one cycle. The state is first masked to N bits. Then, for each valid bit i = 0,1,..., with d = `in_data[i]`: f = s[0]^d, s = s>>1, and if f then s ^= (poly masked to N bits). `in_nbits` values above 32 count as 32. A count of 0 leaves the masked state.
- R9: With polynomial 0xEDB88320, N = 32, seed 0xFFFFFFFF, and the bytes of ASCII "123456789" sent one per word with count 8, the state ends at 0x340BC6D9. With polynomial 0xA001, N = 16 and a zero seed, the same bytes give 0xBB3D.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| poly_wr | input | 1 | Polynomial write strobe |
| poly_wdata | input | 32 | Polynomial write value |
| poly_q | output | 32 | Current polynomial |
| width_set_wr | input | 1 | Degree-field set strobe |
| width_set_data | input | 5 | Bits to set in degree field |
| width_clr_wr | input | 1 | Degree-field clear strobe |
| width_clr_data | input | 5 | Bits to clear in degree field |
| width_q | output | 5 | Degree field (degree minus one) |
| init_wr | input | 1 | Seed write strobe |
| init_wdata | input | 32 | Seed write value |
| init_q | output | 32 | Current seed |
| swap_set | input | 1 | Set the mirror-seed flag |
| swap_clr | input | 1 | Clear the mirror-seed flag |
| swap_q | output | 1 | Mirror-seed flag |
| clear_stb | input | 1 | Zero the check state |
| init_stb | input | 1 | Load the seed into the check state |
| state_wr | input | 1 | Direct state write strobe |
| state_wdata | input | 32 | Direct state write value |
| state_q | output | 32 | Check state / result |
| in_valid | input | 1 | Data word valid |
| in_ready | output | 1 | Engine can take a word |
| in_data | input | 32 | Data word |
| in_nbits | input | 6 | Valid bit count of the word |

## Verification
`in_ready` is a combinational function of the strobes, so the bench checks it 1 ns after it drives the inputs at a falling edge. Every register result (`poly_q`, `width_q`, `init_q`, `swap_q` and `state_q`) is due exactly one rising edge after its stimulus. The bench therefore compares each of them at the next falling edge against a model that it advances once per cycle. In that model, the seed load and data update use the configuration as it stood before the edge. The seeded random phase mixes strobe collisions, oversized counts and degree changes. The directed cases pin the two standard check values and the priority rules.

// File: rtl/crc_lfsr_pkg.sv
package crc_lfsr_pkg;

  // Operation applied to the check state at the next edge, in priority order
  typedef enum logic [2:0] {
    OP_HOLD  = 3'd0,
    OP_CLEAR = 3'd1,
    OP_SEED  = 3'd2,
    OP_WRITE = 3'd3,
    OP_DATA  = 3'd4
  } state_op_e;

endpackage

// File: rtl/crc_cfg_regs.sv
module crc_cfg_regs #(
  parameter int STATE_W = 32,
  parameter int WF_W    = $clog2(STATE_W)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               poly_wr,
  input  logic [STATE_W-1:0] poly_wdata,
  input  logic               width_set_wr,
  input  logic [WF_W-1:0]    width_set_data,
  input  logic               width_clr_wr,
  input  logic [WF_W-1:0]    width_clr_data,
  input  logic               init_wr,
  input  logic [STATE_W-1:0] init_wdata,
  input  logic               swap_set,
  input  logic               swap_clr,
  output logic [STATE_W-1:0] poly_q,
  output logic [WF_W-1:0]    width_q,
  output logic [STATE_W-1:0] init_q,
  output logic               swap_q,
  output logic [STATE_W-1:0] deg_mask,
  output logic [STATE_W-1:0] seed_val
);

  logic [WF_W-1:0]    clr_term, set_term;
  logic [STATE_W-1:0] seed_mirror;

  assign clr_term = width_clr_wr ? width_clr_data : '0;
  assign set_term = width_set_wr ? width_set_data : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      poly_q  <= '0;
      width_q <= '0;
      init_q  <= '0;
      swap_q  <= 1'b0;
    end else begin
      if (poly_wr) poly_q <= poly_wdata;
      if (init_wr) init_q <= init_wdata;
      width_q <= (width_q & ~clr_term) | set_term;
      if (swap_set)      swap_q <= 1'b1;
      else if (swap_clr) swap_q <= 1'b0;
    end
  end

  // Degree mask: bit i participates when i <= width_q
  always_comb begin
    for (int i = 0; i < STATE_W; i++) begin
      deg_mask[i]    = (i <= int'(width_q));
      seed_mirror[i] = init_q[STATE_W-1-i];
    end
  end

  assign seed_val = (swap_q ? seed_mirror : init_q) & deg_mask;

  assert_poly_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
    poly_wr |=> poly_q == $past(poly_wdata));

  assert_width_clear_all_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (width_clr_wr && (&width_clr_data) && !width_set_wr) |=> width_q == '0);

  assert_width_set_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
    width_set_wr |=> ((width_q & $past(width_set_data)) == $past(width_set_data)));

  assert_swap_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!swap_set && !swap_clr) |=> $stable(swap_q));

  assert_swap_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    swap_set |=> swap_q);

endmodule

// File: rtl/crc_op_arbiter.sv
module crc_op_arbiter
  import crc_lfsr_pkg::*;
(
  input  logic      clear_stb,
  input  logic      init_stb,
  input  logic      state_wr,
  input  logic      in_valid,
  output logic      in_ready,
  output state_op_e op
);

  assign in_ready = !(clear_stb || init_stb || state_wr);

  always_comb begin
    if (clear_stb)     op = OP_CLEAR;
    else if (init_stb) op = OP_SEED;
    else if (state_wr) op = OP_WRITE;
    else if (in_valid) op = OP_DATA;
    else               op = OP_HOLD;
  end

endmodule

// File: rtl/crc_bit_engine.sv
module crc_bit_engine #(
  parameter int STATE_W = 32,
  parameter int DATA_W  = 32,
  parameter int NB_W    = $clog2(DATA_W+1)
) (
  input  logic [STATE_W-1:0] state_in,
  input  logic [STATE_W-1:0] poly,
  input  logic [STATE_W-1:0] deg_mask,
  input  logic [DATA_W-1:0]  data,
  input  logic [NB_W-1:0]    nbits,
  output logic [NB_W-1:0]    nbits_eff,
  output logic [STATE_W-1:0] state_out
);

  logic [STATE_W-1:0] pm;
  logic [STATE_W-1:0] s;
  logic               fb;

  assign nbits_eff = (nbits > NB_W'(DATA_W)) ? NB_W'(DATA_W) : nbits;
  assign pm        = poly & deg_mask;

  // Reflected (LSB-first) Galois update, unrolled over the word
  always_comb begin
    s  = state_in & deg_mask;
    fb = 1'b0;
    for (int i = 0; i < DATA_W; i++) begin
      if (i < int'(nbits_eff)) begin
        fb = s[0] ^ data[i];
        s  = s >> 1;
        if (fb) s = s ^ pm;
      end
    end
    state_out = s;
  end

endmodule

// File: rtl/crc_state_reg.sv
module crc_state_reg
  import crc_lfsr_pkg::*;
#(
  parameter int STATE_W = 32,
  parameter int NB_W    = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  state_op_e          op,
  input  logic [STATE_W-1:0] seed_val,
  input  logic [STATE_W-1:0] wdata,
  input  logic [STATE_W-1:0] deg_mask,
  input  logic [STATE_W-1:0] data_next,
  input  logic [NB_W-1:0]    nbits_eff,
  output logic [STATE_W-1:0] state_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= '0;
    end else begin
      case (op)
        OP_CLEAR: state_q <= '0;
        OP_SEED:  state_q <= seed_val;
        OP_WRITE: state_q <= wdata & deg_mask;
        OP_DATA:  state_q <= data_next;
        default:  state_q <= state_q;
      endcase
    end
  end

  assert_clear_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    op == OP_CLEAR |=> state_q == '0);

  assert_seed_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    op == OP_SEED |=> state_q == $past(seed_val));

  assert_direct_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    op == OP_WRITE |=> state_q == $past(wdata & deg_mask));

  assert_hold_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    op == OP_HOLD |=> $stable(state_q));

  assert_zero_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_DATA && nbits_eff == '0) |=> state_q == $past(state_q & deg_mask));

endmodule

// File: rtl/crc_lfsr_engine.sv
module crc_lfsr_engine
  import crc_lfsr_pkg::*;
#(
  parameter int STATE_W = 32,
  parameter int DATA_W  = 32,
  parameter int WF_W    = $clog2(STATE_W),
  parameter int NB_W    = $clog2(DATA_W+1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               poly_wr,
  input  logic [STATE_W-1:0] poly_wdata,
  output logic [STATE_W-1:0] poly_q,
  input  logic               width_set_wr,
  input  logic [WF_W-1:0]    width_set_data,
  input  logic               width_clr_wr,
  input  logic [WF_W-1:0]    width_clr_data,
  output logic [WF_W-1:0]    width_q,
  input  logic               init_wr,
  input  logic [STATE_W-1:0] init_wdata,
  output logic [STATE_W-1:0] init_q,
  input  logic               swap_set,
  input  logic               swap_clr,
  output logic               swap_q,
  input  logic               clear_stb,
  input  logic               init_stb,
  input  logic               state_wr,
  input  logic [STATE_W-1:0] state_wdata,
  output logic [STATE_W-1:0] state_q,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [DATA_W-1:0]  in_data,
  input  logic [NB_W-1:0]    in_nbits
);

  logic [STATE_W-1:0] deg_mask;
  logic [STATE_W-1:0] seed_val;
  logic [STATE_W-1:0] data_next;
  logic [NB_W-1:0]    nbits_eff;
  state_op_e          op;

  crc_cfg_regs #(.STATE_W(STATE_W), .WF_W(WF_W)) u_cfg (
    .clk(clk), .rst_n(rst_n),
    .poly_wr(poly_wr), .poly_wdata(poly_wdata),
    .width_set_wr(width_set_wr), .width_set_data(width_set_data),
    .width_clr_wr(width_clr_wr), .width_clr_data(width_clr_data),
    .init_wr(init_wr), .init_wdata(init_wdata),
    .swap_set(swap_set), .swap_clr(swap_clr),
    .poly_q(poly_q), .width_q(width_q), .init_q(init_q), .swap_q(swap_q),
    .deg_mask(deg_mask), .seed_val(seed_val)
  );

  crc_op_arbiter u_arb (
    .clear_stb(clear_stb), .init_stb(init_stb), .state_wr(state_wr),
    .in_valid(in_valid), .in_ready(in_ready), .op(op)
  );

  crc_bit_engine #(.STATE_W(STATE_W), .DATA_W(DATA_W), .NB_W(NB_W)) u_eng (
    .state_in(state_q), .poly(poly_q), .deg_mask(deg_mask),
    .data(in_data), .nbits(in_nbits),
    .nbits_eff(nbits_eff), .state_out(data_next)
  );

  crc_state_reg #(.STATE_W(STATE_W), .NB_W(NB_W)) u_state (
    .clk(clk), .rst_n(rst_n), .op(op),
    .seed_val(seed_val), .wdata(state_wdata), .deg_mask(deg_mask),
    .data_next(data_next), .nbits_eff(nbits_eff), .state_q(state_q)
  );

  assert_no_take_on_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_stb || init_stb || state_wr) |-> !in_ready);

  assert_idle_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(clear_stb || init_stb || state_wr) |-> in_ready);

endmodule

// File: tb/crc_lfsr_engine_bench.sv
module crc_lfsr_engine_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        poly_wr = 0, width_set_wr = 0, width_clr_wr = 0, init_wr = 0;
  logic        swap_set = 0, swap_clr = 0, clear_stb = 0, init_stb = 0, state_wr = 0;
  logic        in_valid = 0;
  logic [31:0] poly_wdata = 0, init_wdata = 0, state_wdata = 0, in_data = 0;
  logic [4:0]  width_set_data = 0, width_clr_data = 0;
  logic [5:0]  in_nbits = 0;
  logic [31:0] poly_q, init_q, state_q;
  logic [4:0]  width_q;
  logic        swap_q, in_ready;

  int checks = 0, fails = 0;
  bit done = 0;

  logic [31:0] m_poly = 0, m_init = 0, m_state = 0;
  logic [4:0]  m_width = 0;
  logic        m_swap = 0;

  always #10 clk = ~clk;

  crc_lfsr_engine u_crc_lfsr_engine (
    .clk(clk), .rst_n(rst_n),
    .poly_wr(poly_wr), .poly_wdata(poly_wdata), .poly_q(poly_q),
    .width_set_wr(width_set_wr), .width_set_data(width_set_data),
    .width_clr_wr(width_clr_wr), .width_clr_data(width_clr_data), .width_q(width_q),
    .init_wr(init_wr), .init_wdata(init_wdata), .init_q(init_q),
    .swap_set(swap_set), .swap_clr(swap_clr), .swap_q(swap_q),
    .clear_stb(clear_stb), .init_stb(init_stb),
    .state_wr(state_wr), .state_wdata(state_wdata), .state_q(state_q),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_nbits(in_nbits)
  );

  function automatic logic [31:0] f_mask(input logic [4:0] w);
    return (w == 5'd31) ? 32'hFFFF_FFFF : ((32'h1 << (w + 1)) - 32'h1);
  endfunction

  function automatic logic [31:0] f_mirror(input logic [31:0] v);
    logic [31:0] r;
    for (int k = 0; k < 32; k++) r[31-k] = v[k];
    return r;
  endfunction

  function automatic logic [31:0] f_step(input logic [31:0] s0, input logic [31:0] p,
                                         input logic [4:0] w, input logic [31:0] d,
                                         input int n);
    logic [31:0] m, s;
    int cnt;
    m = f_mask(w);
    s = s0 & m;
    cnt = (n > 32) ? 32 : n;
    for (int k = 0; k < cnt; k++) begin
      if (s[0] != d[k]) s = (s >> 1) ^ (p & m);
      else              s = s >> 1;
    end
    return s;
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    poly_wr = 0; width_set_wr = 0; width_clr_wr = 0; init_wr = 0;
    swap_set = 0; swap_clr = 0; clear_stb = 0; init_stb = 0; state_wr = 0;
    in_valid = 0;
  endtask

  // Inputs have just been driven at a falling edge: check ready, advance the
  // model across the next rising edge, compare at the following falling edge.
  task automatic tick(input string tag);
    logic        exp_rdy;
    logic [31:0] nx;
    #1;
    exp_rdy = !(clear_stb || init_stb || state_wr);
    chk({31'b0, in_ready}, {31'b0, exp_rdy}, {"R7 ready ", tag});
    nx = m_state;
    if (clear_stb)     nx = 32'h0;
    else if (init_stb) nx = (m_swap ? f_mirror(m_init) : m_init) & f_mask(m_width);
    else if (state_wr) nx = state_wdata & f_mask(m_width);
    else if (in_valid) nx = f_step(m_state, m_poly, m_width, in_data, int'(in_nbits));
    m_state = nx;
    if (poly_wr) m_poly = poly_wdata;
    if (init_wr) m_init = init_wdata;
    m_width = (m_width & ~(width_clr_wr ? width_clr_data : 5'h0)) |
              (width_set_wr ? width_set_data : 5'h0);
    if (swap_set)      m_swap = 1'b1;
    else if (swap_clr) m_swap = 1'b0;
    @(negedge clk);
    chk(state_q, m_state, {"R4/R5/R6/R8 state ", tag});
    chk(poly_q, m_poly, {"R1 poly ", tag});
    chk({27'b0, width_q}, {27'b0, m_width}, {"R2 width ", tag});
    chk(init_q, m_init, {"R3 seed ", tag});
    chk({31'b0, swap_q}, {31'b0, m_swap}, {"R3 swap ", tag});
    idle_inputs();
  endtask

  task automatic set_degree(input logic [4:0] w);
    width_clr_wr = 1; width_clr_data = 5'h1f; width_set_wr = 1; width_set_data = w;
    tick("degree");
  endtask

  task automatic run_check_string(output logic [31:0] res);
    byte msg [9] = '{8'h31, 8'h32, 8'h33, 8'h34, 8'h35, 8'h36, 8'h37, 8'h38, 8'h39};
    for (int k = 0; k < 9; k++) begin
      in_valid = 1; in_data = {24'h0, msg[k]}; in_nbits = 6'd8;
      tick("r9_byte");
    end
    res = state_q;
  endtask

  initial begin
    logic [31:0] res;
    repeat (3) @(negedge clk);
    // R1 / R3 / R11-style reset state
    chk(state_q, 32'h0, "R1 reset state");
    chk(poly_q, 32'h0, "R1 reset poly");
    chk({27'b0, width_q}, 32'h0, "R1 reset width");
    chk({31'b0, swap_q}, 32'h0, "R1 reset swap");
    rst_n = 1;
    @(negedge clk);

    // R9: standard reflected CRC-32 check value
    poly_wr = 1; poly_wdata = 32'hEDB8_8320; init_wr = 1; init_wdata = 32'hFFFF_FFFF;
    tick("cfg32");
    set_degree(5'd31);
    init_stb = 1; tick("seed32");
    run_check_string(res);
    chk(res, 32'h340B_C6D9, "R9 crc32 check");

    // R9: 16-bit reflected polynomial
    poly_wr = 1; poly_wdata = 32'h0000_A001; tick("cfg16");
    set_degree(5'd15);
    clear_stb = 1; tick("clr16");
    run_check_string(res);
    chk(res, 32'h0000_BB3D, "R9 crc16 check");

    // R2: set wins over clear on the same bit; clear all empties the field
    width_clr_wr = 1; width_clr_data = 5'h1f; tick("r2_clear_all");
    chk({27'b0, width_q}, 32'h0, "R2 clear all");
    width_set_wr = 1; width_set_data = 5'h05; width_clr_wr = 1; width_clr_data = 5'h04;
    tick("r2_set_wins");
    chk({27'b0, width_q}, 32'h5, "R2 set wins");
    set_degree(5'd31);

    // R4: clear overrides seed load and direct write, and blocks data
    state_wr = 1; state_wdata = 32'h1234_5678; tick("r6_write");
    chk(state_q, 32'h1234_5678, "R6 direct write");
    clear_stb = 1; init_stb = 1; state_wr = 1; in_valid = 1; in_nbits = 6'd8;
    tick("r4_all_strobes");
    chk(state_q, 32'h0, "R4 clear priority");

    // R5: mirrored seed, seed beats direct write
    init_wr = 1; init_wdata = 32'h0000_00F1; swap_set = 1; tick("r5_cfg");
    init_stb = 1; state_wr = 1; state_wdata = 32'hDEAD_BEEF; tick("r5_mirror");
    chk(state_q, 32'h8F00_0000, "R5 mirrored seed");
    swap_clr = 1; swap_set = 1; tick("r3_both");
    chk({31'b0, swap_q}, 32'h1, "R3 set wins");
    swap_clr = 1; tick("r3_clr");

    // R8: oversized count behaves as 32, zero count holds
    in_valid = 1; in_data = 32'hA5A5_0F0F; in_nbits = 6'd63; tick("r8_clamp");
    in_valid = 1; in_nbits = 6'd0; tick("r8_zero");

    // Seeded random mix
    void'($urandom(32'h1357_9BDF));
    for (int it = 0; it < 3000; it++) begin
      int r;
      r = int'($urandom_range(0, 99));
      clear_stb = (r < 4);
      init_stb  = ($urandom_range(0, 19) == 0);
      state_wr  = ($urandom_range(0, 14) == 0);
      state_wdata = $urandom();
      in_valid  = ($urandom_range(0, 2) != 0);
      in_data   = $urandom();
      in_nbits  = 6'($urandom_range(0, 40));
      poly_wr   = ($urandom_range(0, 49) == 0);
      poly_wdata = $urandom();
      init_wr   = ($urandom_range(0, 29) == 0);
      init_wdata = $urandom();
      swap_set  = ($urandom_range(0, 29) == 0);
      swap_clr  = ($urandom_range(0, 29) == 0);
      width_clr_wr = ($urandom_range(0, 39) == 0);
      width_clr_data = 5'($urandom());
      width_set_wr = ($urandom_range(0, 39) == 0);
      width_set_data = 5'($urandom());
      tick("random");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule